// File: doc/BRIEF.md
# Retentive Step Timer

This block measures accumulated "on" time in units of controller scans. A single-cycle tick strobe marks each scan. While the run input is high, each tick adds one unit to an internal count until the count reaches the programmed limit. Unlike a plain on-delay timer, the count is kept when the run input drops. Only an explicit clear request, applied on a tick, or the block reset returns it to zero.

The status outputs are combinational. They are derived from the run input, the limit and the stored count. The complete flag and the in-progress flag are both forced low while the run input is low. Turning time into real units is left to whatever generates the tick strobe.

Top module: `retentive_timer`

## Requirements
- R1: `enabled_o` equals `enable_i` in every cycle.
- R2: `done_o` is high exactly when `enable_i` is high and `accum_o` >= `preset_i` (unsigned).
- R3: `timing_o` is high exactly when `enable_i` is high and `accum_o` < `preset_i` (unsigned). `done_o` and `timing_o` are never high together.
- R4: On a clock edge with `tick_i` high and `clear_i` high, `accum_o` becomes 0, whatever the state of `enable_i` and the count.
- R5: On a clock edge with `tick_i` high, `clear_i` low, `enable_i` high and `accum_o` < `preset_i`, `accum_o` increases by exactly one.
- R6: On a clock edge with `tick_i` high, `clear_i` low and `enable_i` low, `accum_o` keeps its value, so accumulated time is retained.
- R7: On a clock edge with `tick_i` high, `clear_i` low and `accum_o` >= `preset_i`, `accum_o` holds. The count never passes the limit and never wraps, even at the largest limit.
- R8: On a clock edge with `tick_i` low, `accum_o` holds, including when `clear_i` is high.
- R9: A clock edge with `rst_n` low sets `accum_o` to 0.
- R10: If `preset_i` is lowered below the current count, `accum_o` holds and `done_o` is high while `enable_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; zeroes the count |
| tick_i | input | 1 | One-cycle scan strobe; the count changes only on these edges |
| enable_i | input | 1 | Run request |
| clear_i | input | 1 | Count clear request, acted on with a tick |
| preset_i | input | ACC_W | Count limit |
| enabled_o | output | 1 | Copy of the run request |
| done_o | output | 1 | Run request high and limit reached |
| timing_o | output | 1 | Run request high and limit not reached |
| accum_o | output | ACC_W | Current count |

## Verification
The bench targets the retention path. A timer that clears on run loss would show a count of zero after the run input is re-asserted, instead of the value it held before. It drives a clear without a tick to catch a design that acts on the clear asynchronously to the scan. It also drives a clear and a run request together to catch a design that lets counting win over the clear. It lowers the limit below the count, which exposes a design that compares for equality rather than greater-or-equal, because such a design drops the complete flag. It runs past the largest limit to catch a count that wraps to zero.

// File: rtl/rto_pkg.sv
// Package: shared types for the retentive step timer.
// Assumes: nothing; holds only type definitions.
package rto_pkg;

    // Count update chosen for one clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_STEP  = 2'd2
    } rto_act_e;

endpackage

// File: rtl/rto_ctrl.sv
// Module: rto_ctrl
// Picks the count update for the current edge from the scan strobe, the
// clear request, the run request and the below-limit compare result.
// Assumes: below_i is the live unsigned compare of the count against the limit.
module rto_ctrl
    import rto_pkg::*;
(
    input  logic     tick_i,
    input  logic     enable_i,
    input  logic     clear_i,
    input  logic     below_i,
    output rto_act_e act_o
);

    // Priority: no tick holds, then clear wins, then step while running below the limit.
    always_comb begin
        act_o = ACT_HOLD;
        if (tick_i) begin
            if (clear_i)
                act_o = ACT_CLEAR;
            else if (enable_i && below_i)
                act_o = ACT_STEP;
        end
    end

endmodule

// File: rtl/rto_accum.sv
// Module: rto_accum
// Holds the retained count and applies the chosen update on each edge.
// Assumes: ACT_STEP is only requested while the count is below the limit,
// so the increment cannot wrap.
module rto_accum
    import rto_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rto_act_e         act_i,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             clear_i,
    input  logic [ACC_W-1:0] preset_i,
    output logic [ACC_W-1:0] acc_o
);

    localparam logic [ACC_W-1:0] ACC_ZERO = '0;
    localparam logic [ACC_W-1:0] ACC_ONE  = ACC_W'(1);

    logic [ACC_W-1:0] acc_q;

    // Count register: synchronous reset, then the selected update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= ACC_ZERO;
        end else begin
            case (act_i)
                ACT_CLEAR: acc_q <= ACC_ZERO;
                ACT_STEP:  acc_q <= acc_q + ACC_ONE;
                default:   acc_q <= acc_q;
            endcase
        end
    end

    assign acc_o = acc_q;

    // Clear on a tick empties the count.
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && clear_i) |=> (acc_o == ACC_ZERO));

    // Running below the limit adds exactly one.
    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clear_i && enable_i && (acc_o < preset_i)) |=> (acc_o == $past(acc_o) + ACC_ONE));

    // Loss of run request keeps the count.
    p_retain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clear_i && !enable_i) |=> $stable(acc_o));

    // At or beyond the limit the count holds.
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clear_i && (acc_o >= preset_i)) |=> $stable(acc_o));

    // No tick, no change.
    p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(acc_o));

endmodule

// File: rtl/rto_status.sv
// Module: rto_status
// Derives the combinational status flags from the run request, the limit
// and the stored count, and provides the below-limit compare to the control logic.
// Assumes: clk and rst_n serve only the local checks.
module rto_status #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [ACC_W-1:0] preset_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             below_o,
    output logic             enabled_o,
    output logic             done_o,
    output logic             timing_o
);

    // Unsigned limit compare and run-gated flags.
    always_comb begin
        below_o   = (acc_i < preset_i);
        enabled_o = enable_i;
        done_o    = enable_i && !below_o;
        timing_o  = enable_i && below_o;
    end

    // Flags are mutually exclusive.
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timing_o));

    // With the run request low, neither flag is raised.
    p_flags_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled_o |-> (!done_o && !timing_o));

    // With the run request high, exactly one flag is raised.
    p_flags_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enabled_o |-> $onehot({done_o, timing_o}));

endmodule

// File: rtl/retentive_timer.sv
// Module: retentive_timer
// Retentive scan-count timer: accumulates ticks while running, keeps the
// count across run loss, and clears only on a ticked clear or block reset.
// Assumes: tick_i is a one-cycle strobe in the clk domain; rst_n is synchronous.
module retentive_timer
    import rto_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             clear_i,
    input  logic [ACC_W-1:0] preset_i,
    output logic             enabled_o,
    output logic             done_o,
    output logic             timing_o,
    output logic [ACC_W-1:0] accum_o
);

    rto_act_e         act;
    logic             below;
    logic [ACC_W-1:0] acc;

    rto_ctrl u_ctrl (
        .tick_i   (tick_i),
        .enable_i (enable_i),
        .clear_i  (clear_i),
        .below_i  (below),
        .act_o    (act)
    );

    rto_accum #(.ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .tick_i   (tick_i),
        .enable_i (enable_i),
        .clear_i  (clear_i),
        .preset_i (preset_i),
        .acc_o    (acc)
    );

    rto_status #(.ACC_W(ACC_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .preset_i  (preset_i),
        .acc_i     (acc),
        .below_o   (below),
        .enabled_o (enabled_o),
        .done_o    (done_o),
        .timing_o  (timing_o)
    );

    assign accum_o = acc;

    // Block reset empties the count.
    p_reset_zero_r9: assert property (@(posedge clk)
        !rst_n |=> (accum_o == '0));

endmodule

// File: tb/retentive_timer_bench.sv
`timescale 1ns/1ps
module retentive_timer_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         en = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] preset = '0;
    logic         enabled, done, timing;
    logic [W-1:0] acc;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    retentive_timer #(.ACC_W(W)) u_retentive_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .enable_i  (en),
        .clear_i   (clr),
        .preset_i  (preset),
        .enabled_o (enabled),
        .done_o    (done),
        .timing_o  (timing),
        .accum_o   (acc)
    );

    // Vector: {en, clr, tick, preset[8], exp_acc[8], exp_done, exp_timing}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 8'd3, 8'd1, 1'b0, 1'b1},  // R5 step
        {1'b1, 1'b0, 1'b0, 8'd3, 8'd1, 1'b0, 1'b1},  // R8 no tick
        {1'b1, 1'b0, 1'b1, 8'd3, 8'd2, 1'b0, 1'b1},  // R5 step
        {1'b0, 1'b0, 1'b1, 8'd3, 8'd2, 1'b0, 1'b0},  // R6 retain
        {1'b0, 1'b0, 1'b1, 8'd3, 8'd2, 1'b0, 1'b0},  // R6 retain
        {1'b1, 1'b0, 1'b1, 8'd3, 8'd3, 1'b1, 1'b0},  // R2 reaches limit
        {1'b1, 1'b0, 1'b1, 8'd3, 8'd3, 1'b1, 1'b0},  // R7 hold at limit
        {1'b1, 1'b0, 1'b1, 8'd2, 8'd3, 1'b1, 1'b0},  // R10 limit lowered
        {1'b0, 1'b0, 1'b1, 8'd2, 8'd3, 1'b0, 1'b0},  // R2 gated by run
        {1'b1, 1'b1, 1'b0, 8'd2, 8'd3, 1'b1, 1'b0},  // R8 clear without tick
        {1'b1, 1'b1, 1'b1, 8'd5, 8'd0, 1'b0, 1'b1},  // R4 clear beats step
        {1'b1, 1'b0, 1'b1, 8'd5, 8'd1, 1'b0, 1'b1},  // R3 timing
        {1'b1, 1'b1, 1'b1, 8'd0, 8'd0, 1'b1, 1'b0},  // R4 clear, zero limit
        {1'b1, 1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 1'b0}   // R7 zero limit holds
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One edge with the given inputs; sample 1 ns after it.
    task automatic step(input logic e, input logic c, input logic t, input logic [W-1:0] p);
        @(negedge clk);
        en = e; clr = c; tick = t; preset = p;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R9 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset count", int'(acc), 0);
        check("R2 reset done", int'(done), 0);
        check("R3 reset timing", int'(timing), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            step(v[20], v[19], v[18], v[17:10]);
            check($sformatf("R1 enabled row %0d", i), int'(enabled), int'(v[20]));
            check($sformatf("R4-R8 count row %0d", i), int'(acc), int'(v[9:2]));
            check($sformatf("R2 done row %0d", i), int'(done), int'(v[1]));
            check($sformatf("R3 timing row %0d", i), int'(timing), int'(v[0]));
        end

        // R7: the largest limit neither overruns nor wraps
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'b1, 8'd255);
        check("R7 max limit count", int'(acc), 255);
        check("R2 max limit done", int'(done), 1);

        // R6: retention after a long idle
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b1, 8'd255);
        check("R6 retained count", int'(acc), 255);

        // R9: block reset mid-run, without a tick
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0;
        @(posedge clk);
        #1;
        check("R9 reset mid-run", int'(acc), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 8'd4);
        check("R5 step after reset", int'(acc), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule